// File: doc/BRIEF.md
# Backlight Register Init Sequencer with Cache Restore

This block runs once at display bring-up, before the adaptive-backlight setup. It prepares the backlight PWM register set. It works through a simple register port. Reads are combinational: the address goes out and the data comes back in the same cycle. Writes are committed by the register file on the clock edge.

On a start pulse the block reads the PWM control word and examines its active-count field. A count of 0 or 1 means the registers were wiped. In that case the block writes back four values saved by an earlier healthy init. If nothing has been saved yet, it writes fixed defaults instead. A count of 2 or more means the registers are sound, and the block copies the four values into its own cache.

In every case it then performs three read-modify-write steps. First it sets the software-ownership bit in a scratch register. Next it sets the PWM enable bit. Last it clears the group lock bit. One cycle after that final write, it raises a one-cycle done pulse.

Register addresses: control 0, control2 1, period 2, reference divider 3, scratch 4, lock 5. Control word fields: active count in bits [15:0] and PWM enable in bit 31. The reference-divider field is bits [11:0] of register 3.

Top module: `bl_reg_init`

## Requirements
- R1: After reset, done and wr_en are low and the cache is empty, so the first corrupted run takes the default path.
- R2: The control word is corrupted when its bits [15:0] equal 0 or 1. A value of 2 or more is healthy.
- R3: On a healthy run, control, control2, period and the reference-divider word are captured into the cache. None of addresses 0 to 3 receives a value other than the read-modify-write of control in R7.
- R4: On a corrupted run with a non-zero cached control word, the block writes control, control2 and period from the cache, in that order. It then replaces bits [11:0] of register 3 with the cached field and keeps that register's other bits.
- R5: On a corrupted run with an empty cache, control becomes 0xC000FA00 and period becomes 0x000C0FA0. Control2 and the reference divider are left untouched.
- R6: After the restore, default or capture step, bit 29 of the scratch register (address 4) is set and its other bits are kept.
- R7: Next, bit 31 of control is set and its other bits are kept.
- R8: Last, bit 0 of the lock register (address 5) is cleared. done is high for exactly one cycle, in the cycle after that write.
- R9: Counted in clock edges from the edge that samples start to the edge after which done is high, the latency is 8 for a healthy run, 9 for a restore and 7 for a default run.
- R10: A start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the cache |
| start | input | 1 | Starts one init sequence when idle |
| rd_addr | output | 3 | Register read address |
| rd_data | input | 32 | Combinational read data for rd_addr |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register write address |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle pulse after the unlock write |

## Verification
The register images are chosen so that the three paths can be told apart.

- An all-zero control word with an empty cache separates the default path from the restore path.
- A healthy image whose count is exactly 2, followed by an image whose count is 1, confirms the corruption boundary. It also confirms that the restore brings back the earlier capture rather than defaults.
- A later healthy image with different contents, followed by a corrupted word whose upper bits are non-zero, shows that the cache is overwritten on each healthy run. It also shows that only the low count bits decide corruption.
- Reference-divider words with busy upper bits show that only the field is replaced. Logged write addresses and latencies expose any reordering.
- A mid-run start pulse exercises R10, and a reset followed by a corrupted run exercises R1.

// File: rtl/bl_init_pkg.sv
package bl_init_pkg;
  parameter int DW = 32;
  parameter int AW = 3;
  parameter int SLOTS = 4;
  parameter int CNT_LSB = 0;
  parameter int CNT_W = 16;
  parameter int CORRUPT_MAX = 1;
  parameter int REF_LSB = 0;
  parameter int REF_W = 12;
  parameter int SW_OWN_BIT = 29;
  parameter int PWM_EN_BIT = 31;
  parameter int LOCK_BIT = 0;
  parameter logic [DW-1:0] DEF_CTRL = 32'hC000_FA00;
  parameter logic [DW-1:0] DEF_PERIOD = 32'h000C_0FA0;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CTRL2 = 3'd1;
  localparam logic [AW-1:0] A_PERIOD = 3'd2;
  localparam logic [AW-1:0] A_REFDIV = 3'd3;
  localparam logic [AW-1:0] A_SCRATCH = 3'd4;
  localparam logic [AW-1:0] A_LOCK = 3'd5;

  localparam logic [DW-1:0] REF_MASK = ((DW'(1) << REF_W) - DW'(1)) << REF_LSB;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_CAP_C2, S_CAP_PER, S_CAP_REF,
    S_RS_CTRL, S_RS_C2, S_RS_PER, S_RS_REF,
    S_DF_CTRL, S_DF_PER, S_TAKE_SW, S_EN_PWM, S_UNLOCK, S_FINISH
  } seq_state_t;

  function automatic logic count_corrupt(input logic [DW-1:0] ctrl);
    logic [CNT_W-1:0] cnt;
    cnt = ctrl[CNT_LSB +: CNT_W];
    return (32'(cnt) <= CORRUPT_MAX);
  endfunction

  function automatic logic [DW-1:0] merge_ref(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] saved);
    return (cur & ~REF_MASK) | (saved & REF_MASK);
  endfunction

  function automatic logic [DW-1:0] set_bit(input logic [DW-1:0] v, input int b);
    return v | (DW'(1) << b);
  endfunction

  function automatic logic [DW-1:0] clr_bit(input logic [DW-1:0] v, input int b);
    return v & ~(DW'(1) << b);
  endfunction
endpackage

// File: rtl/bl_init_cache.sv
module bl_init_cache
  import bl_init_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SLOTS-1:0]           cap_en,
  input  logic [DW-1:0]              din,
  output logic [SLOTS-1:0][DW-1:0]   q,
  output logic                       valid
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)         q[g] <= '0;
      else if (cap_en[g]) q[g] <= din;
    end

    p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[g] |=> $stable(q[g]));
  end

  // Slot 0 holds the control word; valid marks a non-zero capture
  always_ff @(posedge clk) begin
    if (!rst_n)         valid <= 1'b0;
    else if (cap_en[0]) valid <= |din;
  end

  p_valid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (q[0] != '0));
endmodule

// File: rtl/bl_init_seq.sv
module bl_init_seq
  import bl_init_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DW-1:0]            rd_data,
  input  logic [SLOTS-1:0][DW-1:0] cache_q,
  input  logic                     cache_valid,
  output logic [SLOTS-1:0]         cap_en,
  output logic [AW-1:0]            rd_addr,
  output logic                     wr_en,
  output logic [AW-1:0]            wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic                     done
);
  seq_state_t state, nxt;
  logic       corrupt;

  assign corrupt = count_corrupt(rd_data);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt     = state;
    cap_en  = '0;
    rd_addr = A_CTRL;
    wr_en   = 1'b0;
    wr_addr = A_CTRL;
    wr_data = '0;
    unique case (state)
      S_IDLE: if (start) nxt = S_CHECK;
      S_CHECK: begin
        rd_addr = A_CTRL;
        if (!corrupt) begin
          cap_en[0] = 1'b1;
          nxt       = S_CAP_C2;
        end else if (cache_valid) begin
          nxt = S_RS_CTRL;
        end else begin
          nxt = S_DF_CTRL;
        end
      end
      S_CAP_C2:  begin rd_addr = A_CTRL2;  cap_en[1] = 1'b1; nxt = S_CAP_PER; end
      S_CAP_PER: begin rd_addr = A_PERIOD; cap_en[2] = 1'b1; nxt = S_CAP_REF; end
      S_CAP_REF: begin rd_addr = A_REFDIV; cap_en[3] = 1'b1; nxt = S_TAKE_SW; end
      S_RS_CTRL: begin wr_en = 1'b1; wr_addr = A_CTRL;   wr_data = cache_q[0]; nxt = S_RS_C2;  end
      S_RS_C2:   begin wr_en = 1'b1; wr_addr = A_CTRL2;  wr_data = cache_q[1]; nxt = S_RS_PER; end
      S_RS_PER:  begin wr_en = 1'b1; wr_addr = A_PERIOD; wr_data = cache_q[2]; nxt = S_RS_REF; end
      S_RS_REF: begin
        rd_addr = A_REFDIV;
        wr_en   = 1'b1;
        wr_addr = A_REFDIV;
        wr_data = merge_ref(rd_data, cache_q[3]);
        nxt     = S_TAKE_SW;
      end
      S_DF_CTRL: begin wr_en = 1'b1; wr_addr = A_CTRL;   wr_data = DEF_CTRL;   nxt = S_DF_PER;  end
      S_DF_PER:  begin wr_en = 1'b1; wr_addr = A_PERIOD; wr_data = DEF_PERIOD; nxt = S_TAKE_SW; end
      S_TAKE_SW: begin
        rd_addr = A_SCRATCH; wr_en = 1'b1; wr_addr = A_SCRATCH;
        wr_data = set_bit(rd_data, SW_OWN_BIT); nxt = S_EN_PWM;
      end
      S_EN_PWM: begin
        rd_addr = A_CTRL; wr_en = 1'b1; wr_addr = A_CTRL;
        wr_data = set_bit(rd_data, PWM_EN_BIT); nxt = S_UNLOCK;
      end
      S_UNLOCK: begin
        rd_addr = A_LOCK; wr_en = 1'b1; wr_addr = A_LOCK;
        wr_data = clr_bit(rd_data, LOCK_BIT); nxt = S_FINISH;
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign done = (state == S_FINISH);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> (state != S_CHECK));

  p_capture_excludes_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_en) |-> !wr_en);
endmodule

// File: rtl/bl_reg_init.sv
module bl_reg_init
  import bl_init_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [2:0]    rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [2:0]    wr_addr,
  output logic [31:0]   wr_data,
  output logic          done
);
  logic [SLOTS-1:0]         cap_en;
  logic [SLOTS-1:0][DW-1:0] cache_q;
  logic                     cache_valid;

  bl_init_cache u_cache (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_en(cap_en),
    .din   (rd_data),
    .q     (cache_q),
    .valid (cache_valid)
  );

  bl_init_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_data    (rd_data),
    .cache_q    (cache_q),
    .cache_valid(cache_valid),
    .cap_en     (cap_en),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (done)
  );

  p_unlock_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_en) && ($past(wr_addr) == A_LOCK)));

  p_pwm_before_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LOCK) |-> ($past(wr_en) && ($past(wr_addr) == A_CTRL)));
endmodule

// File: tb/bl_reg_init_bench.sv
module bl_reg_init_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, wr_en, done;
  logic [2:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  logic [31:0] rf [6];
  logic [31:0] ld_v [6];
  logic        ld;
  logic [2:0]  wlog [16];
  int          wcnt;

  int n_chk = 0, n_fail = 0, cyc = 0;

  bl_reg_init u_bl_reg_init (.clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  assign rd_data = (rd_addr < 3'd6) ? rf[rd_addr] : 32'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld) begin
      for (int i = 0; i < 6; i++) rf[i] <= ld_v[i];
      wcnt <= 0;
    end else if (wr_en && wr_addr < 3'd6) begin
      rf[wr_addr] <= wr_data;
      if (wcnt < 16) wlog[wcnt] <= wr_addr;
      wcnt <= wcnt + 1;
    end
  end

  // Rows: control, control2, period, refdiv, scratch, lock
  localparam logic [31:0] VEC [5][6] = '{
    '{32'h0000_0000, 32'h0000_1234, 32'h0008_0100, 32'hABC0_0555, 32'h0000_00FF, 32'h0000_0101},
    '{32'h4000_0002, 32'h5555_AAAA, 32'h000A_03E8, 32'h7770_0123, 32'h2000_0000, 32'h0000_0001},
    '{32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_F000, 32'h0000_0000, 32'h0000_0001},
    '{32'h0000_FA00, 32'h0000_0007, 32'h000C_0FA0, 32'h0000_0ABC, 32'h0000_0001, 32'hFFFF_FFFF},
    '{32'h0001_0000, 32'hDEAD_BEEF, 32'h0000_0001, 32'h1230_0000, 32'h2000_0000, 32'h0000_0000}
  };

  logic [31:0] mc [4];
  logic        mvalid;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Loads an image, runs one sequence and checks all results against the model
  task automatic run_one(input logic [31:0] v [6], input int extra_at);
    logic [31:0] e [6];
    logic [2:0]  ord [8];
    int nord, lat, n;
    logic corrupt;
    for (int i = 0; i < 6; i++) e[i] = v[i];
    nord = 0;
    corrupt = (v[0][15:0] < 16'd2);  // R2 boundary
    if (corrupt && mvalid) begin
      e[0] = mc[0]; e[1] = mc[1]; e[2] = mc[2];
      e[3] = {v[3][31:12], mc[3][11:0]};
      ord[0] = 3'd0; ord[1] = 3'd1; ord[2] = 3'd2; ord[3] = 3'd3; nord = 4; lat = 9;
    end else if (corrupt) begin
      e[0] = 32'hC000_FA00; e[2] = 32'h000C_0FA0;
      ord[0] = 3'd0; ord[1] = 3'd2; nord = 2; lat = 7;
    end else begin
      for (int i = 0; i < 4; i++) mc[i] = v[i];
      mvalid = (v[0] != 0);
      lat = 8;
    end
    e[4] = e[4] | 32'h2000_0000;
    e[0] = e[0] | 32'h8000_0000;
    e[5] = e[5] & ~32'h1;
    ord[nord] = 3'd4; ord[nord+1] = 3'd0; ord[nord+2] = 3'd5; nord += 3;

    @(negedge clk); for (int i = 0; i < 6; i++) ld_v[i] = v[i]; ld = 1'b1;
    @(negedge clk); ld = 1'b0; start = 1'b1;
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      start = (n == extra_at);
      if (done || n > 40) break;
    end
    start = 1'b0;
    chk("R9 latency", 32'(n), 32'(lat));
    chk(corrupt ? (mvalid ? "R4 control" : "R5 control") : "R3 control", rf[0], e[0]);
    chk(corrupt && mvalid ? "R4 control2" : "R5/R3 control2", rf[1], e[1]);
    chk(corrupt ? "R5/R4 period" : "R3 period", rf[2], e[2]);
    chk("R4 refdiv field", rf[3], e[3]);
    chk("R6 scratch", rf[4], e[4]);
    chk("R8 lock", rf[5], e[5]);
    chk("R8 write count", 32'(wcnt), 32'(nord));
    for (int i = 0; i < nord && i < 16; i++) chk("R7 write order", 32'(wlog[i]), 32'(ord[i]));
    @(negedge clk);
    chk("R8 done pulse width", 32'(done), 32'd0);
    if (extra_at > 0) begin
      repeat (12) begin
        @(negedge clk);
        chk("R10 no second run", 32'(done | wr_en), 32'd0);
      end
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] row [6];
    rst_n = 1'b0; start = 1'b0; ld = 1'b0; mvalid = 1'b0;
    for (int i = 0; i < 6; i++) ld_v[i] = '0;
    for (int i = 0; i < 4; i++) mc[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 done at reset", 32'(done), 32'd0);
    chk("R1 wr_en at reset", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(wr_en | done), 32'd0);

    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 6; i++) row[i] = VEC[r][i];
      run_one(row, 0);
    end

    // R10: start pulse in the middle of a healthy run
    for (int i = 0; i < 6; i++) row[i] = VEC[1][i];
    run_one(row, 3);

    // R1: reset clears the cache, so a corrupted image takes the default path
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    mvalid = 1'b0;
    for (int i = 0; i < 6; i++) row[i] = VEC[2][i];
    run_one(row, 0);

    finish_run();
  end
endmodule